// File: doc/BRIEF.md
# Add/Subtract/Compare Unit with Carry and Zero Flags

This block is the arithmetic slice of a small processor core. On each cycle it receives two operands, an operation code and a valid strobe. It returns the operation's result with a destination write-enable in the same cycle. Two one-bit status flags, carry and zero, sit inside the unit. They change at the clock edge, and only when the executing operation is one that is allowed to touch them. Between such operations they hold their value for any number of cycles.

Subtraction runs through the adder with the second operand inverted and a carry-in of one. The carry flag after a subtraction therefore means that no borrow occurred. Both compare operations, unsigned and signed, update the flags like a subtraction but never raise the write-enable. A carry-conditional input lets any operation run only when the carry flag is currently set. When the flag is clear, the operation is squashed: it has no write and no flag change.

Top module: `aluFlagUnit`

## Requirements
- R1: Opcode 0 (add) with an executing operation drives result = (opA + opB) mod 2^W with resultWe = 1, and at the next edge carry becomes the bit carried out of the W-bit sum (16-bit: 0x5678+0xCDEF sets it, 0x5678+0x1234 clears it).
- R2: Opcode 1 (subtract) drives result = (opA - opB) mod 2^W with resultWe = 1, and carry becomes 1 exactly when opA >= opB unsigned (no borrow): 3-4 gives 0, 4-4 and 5-4 give 1.
- R3: Opcode 2 (unsigned compare) keeps resultWe = 0 and updates carry and zero exactly as opcode 1 would.
- R4: Opcode 3 (signed compare) keeps resultWe = 0, sets carry exactly when opA >= opB as two's-complement values, and sets zero exactly when opA equals opB.
- R5: After opcodes 0 to 3, the zero flag is 1 exactly when the full W-bit arithmetic result is all zeros, whether or not that result is written.
- R6: Opcode 4 (move) drives result = opB with resultWe = 1 and leaves both flags unchanged.
- R7: Opcodes 5, 6 and 7 are inert: resultWe = 0 and both flags are unchanged.
- R8: With condCarry = 1, an operation executes only if the carry flag is 1. Otherwise resultWe = 0 and both flags are unchanged.
- R9: With opValid = 0, resultWe = 0 and both flags are unchanged.
- R10: An active-low asynchronous reset clears both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | Operation: 0 add, 1 subtract, 2 unsigned compare, 3 signed compare, 4 move, 5-7 inert |
| condCarry | input | 1 | Execute only if the carry flag is set |
| opA | input | W | First operand (minuend for subtract) |
| opB | input | W | Second operand (subtrahend; source of move) |
| result | output | W | Result value, meaningful when resultWe is 1 |
| resultWe | output | 1 | Destination write-enable |
| carryFlag | output | 1 | Persistent carry / no-borrow flag |
| zeroFlag | output | 1 | Persistent zero flag |

## Verification
The stimulus table reproduces the worked add and subtract cases around the word boundary, which separates a real carry-out from a truncated sum and "no borrow" from "borrow". Compare pairs chosen so that the unsigned and signed orderings disagree (0x8000 against 0x0001, 0xFFFF against 0x0000) show whether the signed compare uses the sign-corrected ordering rather than the raw adder carry. Move, inert codes, idle cycles and squashed conditional operations follow operations that leave the flags at non-reset values, so a flag that is wrongly touched becomes visible. A long run of random operands with random opcodes, conditions and valid gaps is compared against a wide-integer model.

// File: rtl/aluFlagPkg.sv
package aluFlagPkg;

  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_ADD  = 3'd0;
  localparam logic [OPW-1:0] OP_SUB  = 3'd1;
  localparam logic [OPW-1:0] OP_CMPU = 3'd2;
  localparam logic [OPW-1:0] OP_CMPS = 3'd3;
  localparam logic [OPW-1:0] OP_MOVE = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic writeDest;   // raise the destination write-enable
    logic setCarry;    // load carry at the edge
    logic setZero;     // load zero at the edge
    logic negateB;     // invert opB, carry-in of one
    logic signedOrder; // carry takes the signed ordering
    logic passB;       // result is opB unchanged
  } aluStrobe_t;

endpackage

// File: rtl/aluFlagCtrl.sv
module aluFlagCtrl
  import aluFlagPkg::*;
(
  input  logic           opValid,
  input  logic [OPW-1:0] opCode,
  input  logic           condCarry,
  input  logic           carryFlag,
  output aluStrobe_t     strobe
);

  logic execute;

  assign execute = opValid && (!condCarry || carryFlag);

  always_comb begin
    strobe = '0;
    if (execute) begin
      case (opCode)
        OP_ADD: begin
          strobe.writeDest = 1'b1;
          strobe.setCarry  = 1'b1;
          strobe.setZero   = 1'b1;
        end
        OP_SUB: begin
          strobe.writeDest = 1'b1;
          strobe.setCarry  = 1'b1;
          strobe.setZero   = 1'b1;
          strobe.negateB   = 1'b1;
        end
        OP_CMPU: begin
          strobe.setCarry  = 1'b1;
          strobe.setZero   = 1'b1;
          strobe.negateB   = 1'b1;
        end
        OP_CMPS: begin
          strobe.setCarry    = 1'b1;
          strobe.setZero     = 1'b1;
          strobe.negateB     = 1'b1;
          strobe.signedOrder = 1'b1;
        end
        OP_MOVE: begin
          strobe.writeDest = 1'b1;
          strobe.passB     = 1'b1;
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/aluFlagDatapath.sv
module aluFlagDatapath
  import aluFlagPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluStrobe_t   strobe,
  output logic [W-1:0] result,
  output logic         carryFlag,
  output logic         zeroFlag
);

  localparam int MSB = W - 1;

  logic [W-1:0] addend;
  logic [W:0]   wideSum;
  logic [W-1:0] sumLow;
  logic         overflow;
  logic         signedGe;
  logic         carryNext;
  logic         zeroNext;

  // One adder serves add, subtract and both compares
  assign addend  = strobe.negateB ? ~opB : opB;
  assign wideSum = {1'b0, opA} + {1'b0, addend} + {{W{1'b0}}, strobe.negateB};
  assign sumLow  = wideSum[W-1:0];

  // Signed ordering: sign of difference corrected by overflow
  assign overflow = (opA[MSB] != opB[MSB]) && (sumLow[MSB] != opA[MSB]);
  assign signedGe = !(sumLow[MSB] ^ overflow);

  assign carryNext = strobe.signedOrder ? signedGe : wideSum[W];
  assign zeroNext  = (sumLow == '0);

  assign result = strobe.passB ? opB : sumLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
      zeroFlag  <= 1'b0;
    end else begin
      if (strobe.setCarry) carryFlag <= carryNext;
      if (strobe.setZero)  zeroFlag  <= zeroNext;
    end
  end

endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit
  import aluFlagPkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opValid,
  input  logic [OPW-1:0] opCode,
  input  logic           condCarry,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic [W-1:0]   result,
  output logic           resultWe,
  output logic           carryFlag,
  output logic           zeroFlag
);

  aluStrobe_t strobe;

  aluFlagCtrl ctrl (
    .opValid   (opValid),
    .opCode    (opCode),
    .condCarry (condCarry),
    .carryFlag (carryFlag),
    .strobe    (strobe)
  );

  aluFlagDatapath #(.W(W)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .strobe    (strobe),
    .result    (result),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag)
  );

  assign resultWe = strobe.writeDest;

endmodule

// File: rtl/aluFlagUnitChecker.sv
module aluFlagUnitChecker
  import aluFlagPkg::*;
#(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           opValid,
  input logic [OPW-1:0] opCode,
  input logic           condCarry,
  input logic [W-1:0]   opA,
  input logic [W-1:0]   opB,
  input logic [W-1:0]   result,
  input logic           resultWe,
  input logic           carryFlag,
  input logic           zeroFlag
);

  logic [W:0] plainSum;
  logic       runs;

  assign plainSum = {1'b0, opA} + {1'b0, opB};
  assign runs     = opValid && !condCarry;

  a_r1_add_carry: assert property (@(posedge clk) disable iff (!rstN)
    runs && opCode == OP_ADD |=> carryFlag == $past(plainSum[W]));

  a_r2_sub_noborrow: assert property (@(posedge clk) disable iff (!rstN)
    runs && opCode == OP_SUB |=> carryFlag == ($past(opA) >= $past(opB)));

  a_r3_cmpu_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    opCode == OP_CMPU |-> !resultWe);

  a_r4_cmps_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    opCode == OP_CMPS |-> !resultWe);

  a_r5_cmp_zero: assert property (@(posedge clk) disable iff (!rstN)
    runs && (opCode == OP_CMPU || opCode == OP_CMPS) |=> zeroFlag == ($past(opA) == $past(opB)));

  a_r6_move_keeps: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OP_MOVE |=> $stable(carryFlag) && $stable(zeroFlag));

  a_r6_move_value: assert property (@(posedge clk) disable iff (!rstN)
    resultWe && opCode == OP_MOVE |-> result == opB);

  a_r7_inert: assert property (@(posedge clk) disable iff (!rstN)
    opCode > OP_MOVE |-> !resultWe ##1 ($stable(carryFlag) && $stable(zeroFlag)));

  a_r8_squash: assert property (@(posedge clk) disable iff (!rstN)
    condCarry && !carryFlag |-> !resultWe ##1 ($stable(carryFlag) && $stable(zeroFlag)));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !resultWe ##1 ($stable(carryFlag) && $stable(zeroFlag)));

  always @(posedge clk) begin
    if (!rstN) begin
      a_r10_reset: assert (!carryFlag && !zeroFlag);
    end
  end

endmodule

bind aluFlagUnit aluFlagUnitChecker #(.W(W)) chk (.*);

// File: tb/aluFlagUnit_test.sv
module aluFlagUnit_test;

  localparam int W = 16;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cond;
  } stim_t;

  localparam int NVEC = 16;
  localparam stim_t TABLE [NVEC] = '{
    '{3'd0, 16'h5678, 16'hCDEF, 1'b0},  // add overflow -> C=1
    '{3'd4, 16'h0000, 16'hBEEF, 1'b0},  // move keeps C=1
    '{3'd0, 16'h5678, 16'h1234, 1'b0},  // add no overflow -> C=0
    '{3'd0, 16'h0001, 16'h0002, 1'b1},  // squashed, C=0
    '{3'd1, 16'h0003, 16'h0004, 1'b0},  // 3-4 -> C=0
    '{3'd1, 16'h0004, 16'h0004, 1'b0},  // 4-4 -> C=1 Z=1
    '{3'd6, 16'h1111, 16'h2222, 1'b0},  // inert
    '{3'd1, 16'h0005, 16'h0004, 1'b0},  // 5-4 -> C=1
    '{3'd0, 16'h0010, 16'h0020, 1'b1},  // conditional, runs
    '{3'd2, 16'h8000, 16'h0001, 1'b0},  // unsigned A>=B
    '{3'd3, 16'h8000, 16'h0001, 1'b0},  // signed A<B
    '{3'd3, 16'h0000, 16'hFFFF, 1'b0},  // signed 0 >= -1
    '{3'd2, 16'h0000, 16'hFFFF, 1'b0},  // unsigned 0 < FFFF
    '{3'd0, 16'hFFFF, 16'h0001, 1'b0},  // wraps to zero, C=1 Z=1
    '{3'd5, 16'h0000, 16'h0000, 1'b0},  // inert
    '{3'd3, 16'h7FFF, 16'h7FFF, 1'b0}   // equal -> C=1 Z=1
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [2:0]   opCode = 3'd0;
  logic         condCarry = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] result;
  logic         resultWe;
  logic         carryFlag;
  logic         zeroFlag;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;
  logic modelC = 1'b0;
  logic modelZ = 1'b0;

  always #10 clk = ~clk;

  aluFlagUnit #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .condCarry(condCarry), .opA(opA), .opB(opB), .result(result),
    .resultWe(resultWe), .carryFlag(carryFlag), .zeroFlag(zeroFlag)
  );

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [2:0] op, input logic cond, input logic valid);
    if (!valid) return "R9";
    if (cond && !modelC) return "R8";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic applyOp(input logic [2:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic cond, input logic valid);
    logic         runIt, expWe, nextC, nextZ;
    logic [W-1:0] expRes;
    logic [W:0]   wide;
    string        tag, ztag;
    @(negedge clk);
    opValid = valid; opCode = op; opA = a; opB = b; condCarry = cond;
    #2;
    tag = tagFor(op, cond, valid);
    runIt = valid && (!cond || modelC);
    nextC = modelC; nextZ = modelZ; expWe = 1'b0; expRes = '0;
    ztag = tag;
    if (runIt) begin
      case (op)
        3'd0: begin
          wide = {1'b0, a} + {1'b0, b};
          expRes = wide[W-1:0]; nextC = wide[W]; nextZ = (expRes == '0); expWe = 1'b1; ztag = "R5";
        end
        3'd1: begin
          expRes = a - b; nextC = (a >= b); nextZ = (a == b); expWe = 1'b1; ztag = "R5";
        end
        3'd2: begin nextC = (a >= b); nextZ = (a == b); ztag = "R5"; end
        3'd3: begin nextC = ($signed(a) >= $signed(b)); nextZ = (a == b); ztag = "R5"; end
        3'd4: begin expRes = b; expWe = 1'b1; end
        default: ;
      endcase
    end
    check(tag, "resultWe", {15'd0, resultWe}, {15'd0, expWe});
    if (expWe) check(tag, "result", result, expRes);
    @(posedge clk);
    #2;
    modelC = nextC; modelZ = nextZ;
    check(tag, "carryFlag", {15'd0, carryFlag}, {15'd0, modelC});
    check(ztag, "zeroFlag", {15'd0, zeroFlag}, {15'd0, modelZ});
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: flags cleared while in reset
    #5;
    check("R10", "carryFlag in reset", {15'd0, carryFlag}, 16'd0);
    check("R10", "zeroFlag in reset", {15'd0, zeroFlag}, 16'd0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;

    // R9: idle cycle after reset
    applyOp(3'd0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++)
      applyOp(TABLE[i].op, TABLE[i].a, TABLE[i].b, TABLE[i].cond, 1'b1);

    // R9: idle with flags set from last vector
    applyOp(3'd1, 16'h0000, 16'h0001, 1'b0, 1'b0);
    // R8: clear carry, then a squashed subtract must not touch flags
    applyOp(3'd2, 16'h0000, 16'h0001, 1'b0, 1'b1);
    applyOp(3'd1, 16'h0002, 16'h0002, 1'b1, 1'b1);
    // R3: set carry via unsigned compare, then conditional move runs
    applyOp(3'd2, 16'h0009, 16'h0009, 1'b0, 1'b1);
    applyOp(3'd4, 16'h0000, 16'h1357, 1'b1, 1'b1);

    // Random operands against the wide-integer model
    for (int i = 0; i < 400; i++) begin
      logic [2:0]   rop;
      logic [W-1:0] ra, rb;
      logic         rc, rv;
      rop = 3'($urandom_range(0, 7));
      ra  = W'($urandom);
      rb  = (i % 7 == 0) ? ra : W'($urandom);
      rc  = ($urandom_range(0, 3) == 0);
      rv  = ($urandom_range(0, 7) != 0);
      applyOp(rop, ra, rb, rc, rv);
    end

    // R10: reset in mid-run clears flags
    applyOp(3'd1, 16'h0007, 16'h0007, 1'b0, 1'b1);
    @(negedge clk);
    opValid = 1'b0;
    rstN = 1'b0;
    #2;
    check("R10", "carryFlag after reset", {15'd0, carryFlag}, 16'd0);
    check("R10", "zeroFlag after reset", {15'd0, zeroFlag}, 16'd0);
    modelC = 1'b0; modelZ = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    applyOp(3'd0, 16'h0001, 16'h0001, 1'b1, 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule